// File: doc/BRIEF.md
# Cumulative Row Boundary Decoder

This block turns a 32-bit physical address into a chip select for one of four memory rows. Each row has an 8-bit upper-limit register holding the top of the row in 16 MB units, matched against the top byte of the address. The rows are laid end to end: a row begins where the populated rows below it end, and row 0 begins at address 0. A row whose limit does not rise above the rows below it holds no memory, and it is never selected.

Software or boot logic programs the four limits through a simple byte write port. Lookups are then presented with an address and a valid strobe. One clock later, the block returns either a one-hot row select or a miss flag. A miss means the address lies above all populated memory.

Top module: `cumdec_row_select`

## Requirements
- R1: After synchronous active-low reset, all four limits read as zero, so every row is empty. `result_valid`, `row_sel` and `row_miss` are all 0, and any lookup then returns a miss.
- R2: A write with `lim_wr_en` high loads `lim_wr_byte` into the limit of the row numbered by `lim_wr_row` (0 to 3) at that clock edge. The other three limits are left unchanged. Lookups presented in the following cycles use the new value.
- R3: Only address bits 31:24 take part in the decode. Bits 23:0 have no effect on the row select or the miss flag.
- R4: Row 0 covers the byte range from 0 up to, but not including, its limit. Its `row_sel` bit is 1 when the address top byte is below limit 0.
- R5: For rows 1 to 3, the base is the highest limit among the rows below it. This equals the previous row's limit when the limits are non-decreasing. `row_sel[n]` is 1 when the address top byte is at or above the base and strictly below limit n.
- R6: A row whose limit is not greater than its base (equal to the previous limit, or below it) is empty, and its `row_sel` bit never asserts.
- R7: `row_miss` is 1 for a lookup that falls in no row, including every address whose top byte is at or above the highest limit. While `result_valid` is 1, exactly one of the five bits {`row_sel`, `row_miss`} is set.
- R8: `result_valid` is 1 exactly one cycle after a cycle in which `addr_valid` was 1. The result uses the limits and address of that cycle. In a cycle after `addr_valid` was 0, `result_valid`, `row_sel` and `row_miss` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_wr_en | input | 1 | Limit write strobe |
| lim_wr_row | input | 2 | Row whose limit is written |
| lim_wr_byte | input | 8 | New limit, in 16 MB units |
| addr_valid | input | 1 | Lookup request strobe |
| addr | input | 32 | Physical address to decode |
| row_sel | output | 4 | One-hot row select (bit n = row n) |
| row_miss | output | 1 | Address lies in no populated row |
| result_valid | output | 1 | Registered lookup result is present |

## Verification
A lookup result appears one clock edge after the edge that captures `addr_valid`. A limit write takes effect at its own edge, so a lookup driven in the cycle after a write already sees the new limit. The bench drives stimulus just after the falling edge and samples outputs at the next falling edge, which is half a period after the registering edge. It then drops the strobe and checks one idle cycle, so every comparison lands in the single cycle its result is due.

// File: rtl/cumdec_pkg.sv
// Package: shared sizing for the cumulative row boundary decoder.
// Assumes the limit byte aligns with the top bits of the address.
package cumdec_pkg;
    parameter int unsigned NUM_ROWS = 4;
    parameter int unsigned ADDR_W   = 32;
    parameter int unsigned LIMIT_W  = 8;
    localparam int unsigned ROW_IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int unsigned LIM_BUS_W = NUM_ROWS * LIMIT_W;
    localparam int unsigned LOW_W     = ADDR_W - LIMIT_W;
endpackage

// File: rtl/cumdec_limit_regs.sv
// Module: holds one upper-limit byte per row, written through a byte port.
// Assumes wr_row addresses a valid row; writes to other indices are dropped.
// Reset clears every limit, which leaves all rows empty.
module cumdec_limit_regs
    import cumdec_pkg::*;
#(
    parameter int unsigned ROWS  = NUM_ROWS,
    parameter int unsigned LIM_W = LIMIT_W,
    parameter int unsigned IDX_W = ROW_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_row,
    input  logic [LIM_W-1:0]      wr_byte,
    output logic [ROWS*LIM_W-1:0] lim_flat
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [LIM_W-1:0] lim_q;
        // Purpose: load this row's limit when the write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q <= '0;
            end else if (wr_en && (wr_row == IDX_W'(r))) begin
                lim_q <= wr_byte;
            end
        end
        assign lim_flat[r*LIM_W +: LIM_W] = lim_q;
    end
endmodule

// File: rtl/cumdec_compare.sv
// Module: combinational range match of the address top byte against
// cumulative limits. A row's base is the running maximum of the limits
// below it, so a row whose limit does not rise above that base is empty
// and matches nothing. Assumes lim_flat is stable during the lookup.
module cumdec_compare
    import cumdec_pkg::*;
#(
    parameter int unsigned ROWS  = NUM_ROWS,
    parameter int unsigned LIM_W = LIMIT_W
) (
    input  logic [ROWS*LIM_W-1:0] lim_flat,
    input  logic [LIM_W-1:0]      addr_hi,
    output logic [ROWS-1:0]       hit,
    output logic                  none
);
    logic [LIM_W-1:0] ceil_v [ROWS+1];

    assign ceil_v[0] = '0;

    for (genvar r = 0; r < ROWS; r++) begin : g_cmp
        logic [LIM_W-1:0] lim_r;
        logic             populated;
        assign lim_r     = lim_flat[r*LIM_W +: LIM_W];
        assign populated = lim_r > ceil_v[r];
        // Purpose: match when base <= addr_hi < limit in a populated row.
        always_comb begin
            hit[r] = populated && (addr_hi >= ceil_v[r]) && (addr_hi < lim_r);
        end
        // Purpose: carry the highest limit seen so far upward.
        always_comb begin
            ceil_v[r+1] = populated ? lim_r : ceil_v[r];
        end
    end

    assign none = ~|hit;
endmodule

// File: rtl/cumdec_out_stage.sv
// Module: registers the lookup result one cycle after the request strobe.
// Assumes hit is one-hot or zero; outputs are cleared on idle cycles.
module cumdec_out_stage
    import cumdec_pkg::*;
#(
    parameter int unsigned ROWS = NUM_ROWS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [ROWS-1:0] hit,
    input  logic            none,
    output logic [ROWS-1:0] sel_q,
    output logic            miss_q,
    output logic            vld_q
);
    // Purpose: capture select/miss on a request, clear them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            miss_q <= 1'b0;
            vld_q  <= 1'b0;
        end else if (req) begin
            sel_q  <= hit;
            miss_q <= none;
            vld_q  <= 1'b1;
        end else begin
            sel_q  <= '0;
            miss_q <= 1'b0;
            vld_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/cumdec_row_select.sv
// Module: top of the cumulative row boundary decoder. Ties together the
// limit registers, the range compare and the output register.
// Assumes limits are programmed before lookups that depend on them.
module cumdec_row_select
    import cumdec_pkg::*;
#(
    parameter int unsigned ROWS  = NUM_ROWS,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned LIM_W = LIMIT_W,
    localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr_en,
    input  logic [IDX_W-1:0] lim_wr_row,
    input  logic [LIM_W-1:0] lim_wr_byte,
    input  logic             addr_valid,
    input  logic [AW-1:0]    addr,
    output logic [ROWS-1:0]  row_sel,
    output logic             row_miss,
    output logic             result_valid
);
    logic [ROWS*LIM_W-1:0] lim_flat;
    logic [LIM_W-1:0]      addr_hi;
    logic [AW-LIM_W-1:0]   addr_low_unused;
    logic [ROWS-1:0]       hit;
    logic                  none;

    assign addr_hi         = addr[AW-1 -: LIM_W];
    assign addr_low_unused = addr[AW-LIM_W-1:0];

    cumdec_limit_regs #(.ROWS(ROWS), .LIM_W(LIM_W), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lim_wr_en),
        .wr_row   (lim_wr_row),
        .wr_byte  (lim_wr_byte),
        .lim_flat (lim_flat)
    );

    cumdec_compare #(.ROWS(ROWS), .LIM_W(LIM_W)) u_cmp (
        .lim_flat (lim_flat),
        .addr_hi  (addr_hi),
        .hit      (hit),
        .none     (none)
    );

    cumdec_out_stage #(.ROWS(ROWS)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (addr_valid),
        .hit    (hit),
        .none   (none),
        .sel_q  (row_sel),
        .miss_q (row_miss),
        .vld_q  (result_valid)
    );
endmodule

// File: rtl/cumdec_row_select_chk.sv
// Checker: temporal properties of the row decoder, bound to the top.
module cumdec_row_select_chk #(
    parameter int unsigned ROWS  = 4,
    parameter int unsigned LIM_W = 8,
    parameter int unsigned IDX_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lim_wr_en,
    input logic [IDX_W-1:0]      lim_wr_row,
    input logic [LIM_W-1:0]      lim_wr_byte,
    input logic                  addr_valid,
    input logic [LIM_W-1:0]      addr_hi,
    input logic [ROWS-1:0]       row_sel,
    input logic                  row_miss,
    input logic                  result_valid,
    input logic [ROWS*LIM_W-1:0] lim_flat
);
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> result_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (!result_valid && row_sel == '0 && !row_miss));
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($countones({row_sel, row_miss}) == 1));
    p_miss_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && row_miss) |-> ($past(addr_hi) >= $past(lim_flat[LIM_W-1:0])));
    p_row0_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && row_sel[0]) |-> ($past(addr_hi) < $past(lim_flat[LIM_W-1:0])));

    for (genvar r = 0; r < ROWS; r++) begin : g_rowchk
        p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (lim_wr_en && lim_wr_row == IDX_W'(r)) |=>
                (lim_flat[r*LIM_W +: LIM_W] == $past(lim_wr_byte)));
        p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(lim_wr_en && lim_wr_row == IDX_W'(r)) |=>
                $stable(lim_flat[r*LIM_W +: LIM_W]));
        if (r > 0) begin : g_nz
            p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (result_valid && row_sel[r]) |->
                    ($past(lim_flat[r*LIM_W +: LIM_W]) > $past(lim_flat[(r-1)*LIM_W +: LIM_W])));
            p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (result_valid && row_sel[r]) |->
                    ($past(addr_hi) >= $past(lim_flat[(r-1)*LIM_W +: LIM_W]) &&
                     $past(addr_hi) <  $past(lim_flat[r*LIM_W +: LIM_W])));
        end
    end
endmodule

bind cumdec_row_select cumdec_row_select_chk #(
    .ROWS(ROWS), .LIM_W(LIM_W), .IDX_W(IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lim_wr_en    (lim_wr_en),
    .lim_wr_row   (lim_wr_row),
    .lim_wr_byte  (lim_wr_byte),
    .addr_valid   (addr_valid),
    .addr_hi      (addr_hi),
    .row_sel      (row_sel),
    .row_miss     (row_miss),
    .result_valid (result_valid),
    .lim_flat     (lim_flat)
);

// File: tb/tb_cumdec_row_select.sv
module tb_cumdec_row_select;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lim_wr_en;
    logic [1:0]  lim_wr_row;
    logic [7:0]  lim_wr_byte;
    logic        addr_valid;
    logic [31:0] addr;
    logic [3:0]  row_sel;
    logic        row_miss;
    logic        result_valid;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] lim_m [4];

    always #2 clk = ~clk;

    cumdec_row_select dut (
        .clk(clk), .rst_n(rst_n),
        .lim_wr_en(lim_wr_en), .lim_wr_row(lim_wr_row), .lim_wr_byte(lim_wr_byte),
        .addr_valid(addr_valid), .addr(addr),
        .row_sel(row_sel), .row_miss(row_miss), .result_valid(result_valid)
    );

    // Expected {sel, miss}: base = highest populated limit below each row.
    function automatic logic [4:0] expect_res(input logic [7:0] hi);
        logic [7:0] base = 8'h00;
        logic [3:0] sel  = 4'b0000;
        for (int r = 0; r < 4; r++) begin
            if (lim_m[r] > base) begin
                if (hi >= base && hi < lim_m[r]) sel[r] = 1'b1;
                base = lim_m[r];
            end
        end
        return {sel, (sel == 4'b0000)};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic write_lim(input int row, input logic [7:0] val);
        lim_wr_en   = 1'b1;
        lim_wr_row  = 2'(row);
        lim_wr_byte = val;
        @(negedge clk);
        lim_wr_en = 1'b0;
        lim_m[row] = val;
    endtask

    // Lookup: result due at the edge after the strobe, sampled at negedge.
    task automatic lookup(input string req, input logic [31:0] a);
        logic [4:0] e;
        e = expect_res(a[31:24]);
        addr_valid = 1'b1;
        addr       = a;
        @(negedge clk);
        addr_valid = 1'b0;
        addr       = $urandom;
        check({req, " R8 valid"}, 32'(result_valid), 32'd1);
        check(req, 32'({row_sel, row_miss}), 32'(e));
        @(negedge clk);
        check("R8 idle", 32'({result_valid, row_sel, row_miss}), 32'd0);
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int r = 0; r < 4; r++) lim_m[r] = 8'h00;
        rst_n = 1'b0; lim_wr_en = 1'b0; lim_wr_row = '0; lim_wr_byte = '0;
        addr_valid = 1'b0; addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", 32'({result_valid, row_sel, row_miss}), 32'd0);
        lookup("R1 empty after reset", 32'h0000_0000);
        lookup("R1 empty after reset high", 32'hFFFF_FFFF);

        write_lim(0, 8'h01); write_lim(1, 8'h03);
        write_lim(2, 8'h03); write_lim(3, 8'h08);
        lookup("R4 R3 row0 top byte", 32'h00FF_FFFF);
        lookup("R4 row0 zero", 32'h0000_0000);
        lookup("R5 row1 at base", 32'h0100_0000);
        lookup("R5 R3 row1 below limit", 32'h02FF_FFFF);
        lookup("R6 row2 empty skipped", 32'h0300_0000);
        lookup("R5 row3 top", 32'h07FF_FFFF);
        lookup("R7 at top limit", 32'h0800_0000);
        lookup("R7 far above", 32'hFF00_0000);

        write_lim(1, 8'h05);
        lookup("R2 new limit used", 32'h0400_0000);
        lookup("R2 row3 unchanged", 32'h0700_0000);

        write_lim(0, 8'h10); write_lim(1, 8'h05);
        write_lim(2, 8'h20); write_lim(3, 8'h30);
        lookup("R6 decreasing row1 empty", 32'h0600_0000);
        lookup("R6 row2 base is running max", 32'h1000_0000);
        lookup("R5 row3", 32'h2F12_3456);
        lookup("R7 above", 32'h3000_0001);
        write_lim(0, 8'hFF);
        lookup("R7 row0 covers up to FE", 32'hFE00_0000);
        lookup("R7 FF is miss", 32'hFF00_0000);

        for (int it = 0; it < 400; it++) begin
            if (it % 8 == 0) begin
                logic [7:0] v [4];
                for (int r = 0; r < 4; r++) v[r] = 8'($urandom);
                if ($urandom_range(0, 2) != 0) begin
                    for (int i = 0; i < 3; i++)
                        for (int j = 0; j < 3 - i; j++)
                            if (v[j] > v[j+1]) begin
                                logic [7:0] t = v[j];
                                v[j] = v[j+1]; v[j+1] = t;
                            end
                end
                if ($urandom_range(0, 3) == 0) v[2] = v[1];
                for (int r = 0; r < 4; r++) write_lim(r, v[r]);
            end
            begin
                logic [31:0] a = $urandom;
                if ($urandom_range(0, 1) == 1)
                    a[31:24] = lim_m[$urandom_range(0, 3)] - 8'($urandom_range(0, 1));
                lookup("R5 R7 random", a);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule